// File: doc/BRIEF.md
# Pipelined Main Control Unit

This block turns the opcode of the instruction sitting in the decode stage into one complete set of control strobes. It then moves those strobes down a chain of stage registers so that each group arrives at its consumer at the right time. The execute group appears one cycle after decode, the memory group two cycles after, and the write-back group three cycles after. Every stage therefore sees only the controls of the instruction that currently occupies it.

Every instruction passes through all stages. A stage that an instruction has no use for receives all-zero strobes and does nothing. Examples are the memory stage of a register-register operation and the write-back stage of a store or a branch. An unrecognised opcode decodes to all zeros in every stage and behaves as a bubble.

The datapath feeds back one signal, the ALU zero flag of the instruction in the memory stage. The block combines it with the branch strobe to select the next-PC source.

Top module: `pipeline_ctrl_unit`

## Requirements
- R1: While reset is asserted, every output is 0, whatever the opcode input carries. After reset is released, the memory and write-back outputs stay 0 until the first decoded instruction reaches those stages.
- R2: The execute strobes (sign-extend, immediate operand select, destination select) reflect the opcode presented one cycle earlier. The opcode encodings are:
  - load = 0x23: extend=1, immediate=1, destination select=0 (rt).
  - store = 0x2B: extend=1, immediate=1.
  - add-immediate = 0x08: extend=1, immediate=1, destination select=0.
  - branch-equal = 0x04: extend=1, immediate=0.
  - register-register = 0x00: extend=0, immediate=0, destination select=1 (rd).
- R3: The 3-bit ALU operation uses the codes 0=add, 1=subtract, 2=and, 3=or, 4=set-less-than.
  - Register-register ops take the code from funct: 0x20→0, 0x22→1, 0x24→2, 0x25→3, 0x2A→4. Any other funct gives 0.
  - Load, store and add-immediate give 0. Branch-equal gives 1.
- R4: The memory strobes reflect the opcode presented two cycles earlier. A load asserts only the memory read strobe, a store only the memory write strobe, and branch-equal only the branch strobe. Every other opcode gives all three at 0.
- R5: The write-back strobes reflect the opcode presented three cycles earlier.
  - A load asserts both register write and memory-to-register.
  - Register-register and add-immediate assert register write only.
  - Store, branch-equal and unknown opcodes give both at 0.
- R6: The PC-target select output is high exactly when the memory-stage branch strobe and the zero flag input are both high, in the same cycle.
- R7: Any opcode outside the five listed decodes to all-zero strobes, with ALU operation 0, in every stage.
- R8: When a different instruction is presented on every cycle, each stage's outputs depend only on the instruction in that stage, with no mixing between neighbours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| idOpcode | input | 6 | Opcode field of the instruction in decode |
| idFunct | input | 6 | Function field of the instruction in decode |
| memAluZero | input | 1 | ALU zero flag of the instruction in the memory stage |
| exExtOp | output | 1 | Execute: sign-extend the immediate |
| exAluSrc | output | 1 | Execute: second ALU operand is the immediate |
| exAluOp | output | 3 | Execute: ALU operation code |
| exRegDst | output | 1 | Execute: destination is rd (1) or rt (0) |
| memRead | output | 1 | Memory: data memory read |
| memWrite | output | 1 | Memory: data memory write |
| memBranch | output | 1 | Memory: instruction is a conditional branch |
| memPcSelTarget | output | 1 | Memory: next PC is the branch target |
| wbMemToReg | output | 1 | Write-back: write data comes from memory |
| wbRegWrite | output | 1 | Write-back: register file write enable |

## Verification
Some properties hold on every cycle, and the assertions check these:
- reset quietness;
- one-hot memory strobes;
- the opcode-to-execute mapping for load, register-register, branch and unknown codes;
- the causal links between stages, such as a memory read only following an immediate-operand execute stage, a memory-to-register write-back only following a memory read, and no write-back after a store or branch;
- the PC-select condition.

The cycle alignment of every field for every opcode and funct value, and the mutual independence of adjacent stages under a mixed back-to-back stream, need a reference timeline. The bench's scenarios supply it, including a branch with the zero flag both set and clear and an unknown funct code.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  localparam int OPC_W   = 6;
  localparam int FN_W    = 6;
  localparam int ALUOP_W = 3;

  localparam logic [OPC_W-1:0] OPC_RR    = 6'h00;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;

  localparam logic [FN_W-1:0] FN_ADD = 6'h20;
  localparam logic [FN_W-1:0] FN_SUB = 6'h22;
  localparam logic [FN_W-1:0] FN_AND = 6'h24;
  localparam logic [FN_W-1:0] FN_OR  = 6'h25;
  localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

  typedef enum logic [ALUOP_W-1:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } aluOp_e;

  typedef struct packed {
    logic   extOp;
    logic   aluSrc;
    aluOp_e aluOp;
    logic   regDst;
  } exCtl_t;

  typedef struct packed {
    logic memRead;
    logic memWrite;
    logic branch;
  } memCtl_t;

  typedef struct packed {
    logic memToReg;
    logic regWrite;
  } wbCtl_t;

  typedef struct packed {
    exCtl_t  ex;
    memCtl_t mem;
    wbCtl_t  wb;
  } ctlBundle_t;

  typedef struct packed {
    memCtl_t mem;
    wbCtl_t  wb;
  } exMemCtl_t;
endpackage

// File: rtl/mpc_alu_sel.sv
module mpc_alu_sel
  import mpc_pkg::*;
(
  input  logic [FN_W-1:0] funct,
  input  logic            useFunct,
  input  aluOp_e          fixedOp,
  output aluOp_e          aluOp
);
  aluOp_e fnOp;

  always_comb begin
    unique case (funct)
      FN_ADD:  fnOp = ALU_ADD;
      FN_SUB:  fnOp = ALU_SUB;
      FN_AND:  fnOp = ALU_AND;
      FN_OR:   fnOp = ALU_OR;
      FN_SLT:  fnOp = ALU_SLT;
      default: fnOp = ALU_ADD;
    endcase
  end

  assign aluOp = useFunct ? fnOp : fixedOp;
endmodule

// File: rtl/mpc_decode.sv
module mpc_decode
  import mpc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output ctlBundle_t       ctl
);
  ctlBundle_t baseCtl;
  logic       useFunct;
  aluOp_e     fixedOp;
  aluOp_e     selOp;

  always_comb begin
    baseCtl  = '0;
    useFunct = 1'b0;
    fixedOp  = ALU_ADD;
    unique case (opcode)
      OPC_RR: begin
        baseCtl.ex.regDst   = 1'b1;
        baseCtl.wb.regWrite = 1'b1;
        useFunct            = 1'b1;
      end
      OPC_LOAD: begin
        baseCtl.ex.extOp    = 1'b1;
        baseCtl.ex.aluSrc   = 1'b1;
        baseCtl.mem.memRead = 1'b1;
        baseCtl.wb.memToReg = 1'b1;
        baseCtl.wb.regWrite = 1'b1;
      end
      OPC_STORE: begin
        baseCtl.ex.extOp     = 1'b1;
        baseCtl.ex.aluSrc    = 1'b1;
        baseCtl.mem.memWrite = 1'b1;
      end
      OPC_BEQ: begin
        baseCtl.ex.extOp   = 1'b1;
        baseCtl.mem.branch = 1'b1;
        fixedOp            = ALU_SUB;
      end
      OPC_ADDI: begin
        baseCtl.ex.extOp    = 1'b1;
        baseCtl.ex.aluSrc   = 1'b1;
        baseCtl.wb.regWrite = 1'b1;
      end
      default: ;
    endcase
  end

  mpc_alu_sel u_aluSel (
    .funct    (funct),
    .useFunct (useFunct),
    .fixedOp  (fixedOp),
    .aluOp    (selOp)
  );

  always_comb begin
    ctl          = baseCtl;
    ctl.ex.aluOp = selOp;
  end
endmodule

// File: rtl/mpc_stage_regs.sv
module mpc_stage_regs
  import mpc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlBundle_t idCtl,
  output exCtl_t     exCtl,
  output memCtl_t    memCtl,
  output wbCtl_t     wbCtl
);
  ctlBundle_t idEx;
  exMemCtl_t  exMem;
  wbCtl_t     memWb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idEx  <= '0;
      exMem <= '0;
      memWb <= '0;
    end else begin
      idEx      <= idCtl;
      exMem.mem <= idEx.mem;
      exMem.wb  <= idEx.wb;
      memWb     <= exMem.wb;
    end
  end

  assign exCtl  = idEx.ex;
  assign memCtl = exMem.mem;
  assign wbCtl  = memWb;
endmodule

// File: rtl/pipeline_ctrl_unit.sv
module pipeline_ctrl_unit
  import mpc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [OPC_W-1:0]   idOpcode,
  input  logic [FN_W-1:0]    idFunct,
  input  logic               memAluZero,
  output logic               exExtOp,
  output logic               exAluSrc,
  output logic [ALUOP_W-1:0] exAluOp,
  output logic               exRegDst,
  output logic               memRead,
  output logic               memWrite,
  output logic               memBranch,
  output logic               memPcSelTarget,
  output logic               wbMemToReg,
  output logic               wbRegWrite
);
  ctlBundle_t idCtl;
  exCtl_t     exCtl;
  memCtl_t    memCtl;
  wbCtl_t     wbCtl;

  mpc_decode u_decode (
    .opcode (idOpcode),
    .funct  (idFunct),
    .ctl    (idCtl)
  );

  mpc_stage_regs u_stages (
    .clk    (clk),
    .rstN   (rstN),
    .idCtl  (idCtl),
    .exCtl  (exCtl),
    .memCtl (memCtl),
    .wbCtl  (wbCtl)
  );

  assign exExtOp        = exCtl.extOp;
  assign exAluSrc       = exCtl.aluSrc;
  assign exAluOp        = exCtl.aluOp;
  assign exRegDst       = exCtl.regDst;
  assign memRead        = memCtl.memRead;
  assign memWrite       = memCtl.memWrite;
  assign memBranch      = memCtl.branch;
  assign memPcSelTarget = memCtl.branch & memAluZero;
  assign wbMemToReg     = wbCtl.memToReg;
  assign wbRegWrite     = wbCtl.regWrite;
endmodule

// File: rtl/mpc_checker.sv
module mpc_checker
  import mpc_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [OPC_W-1:0]   idOpcode,
  input logic               memAluZero,
  input logic               exExtOp,
  input logic               exAluSrc,
  input logic [ALUOP_W-1:0] exAluOp,
  input logic               exRegDst,
  input logic               memRead,
  input logic               memWrite,
  input logic               memBranch,
  input logic               memPcSelTarget,
  input logic               wbMemToReg,
  input logic               wbRegWrite
);
  logic knownOp;
  assign knownOp = (idOpcode == OPC_RR) || (idOpcode == OPC_LOAD) ||
                   (idOpcode == OPC_STORE) || (idOpcode == OPC_BEQ) ||
                   (idOpcode == OPC_ADDI);

  always @(negedge clk) begin
    if (!rstN) begin
      p_reset_quiet_r1: assert ({exExtOp, exAluSrc, exAluOp, exRegDst, memRead, memWrite,
                                 memBranch, memPcSelTarget, wbMemToReg, wbRegWrite} == '0)
        else $error("outputs active during reset");
    end
  end

  p_load_exec_r2: assert property (@(posedge clk) disable iff (!rstN)
    (idOpcode == OPC_LOAD) |=> (exAluSrc && exExtOp && !exRegDst));

  p_rr_exec_r2: assert property (@(posedge clk) disable iff (!rstN)
    (idOpcode == OPC_RR) |=> (exRegDst && !exAluSrc && !exExtOp));

  p_beq_sub_r3: assert property (@(posedge clk) disable iff (!rstN)
    (idOpcode == OPC_BEQ) |=> (exAluOp == 3'd1));

  p_mem_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRead, memWrite, memBranch}));

  p_memacc_after_imm_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memRead || memWrite) |-> $past(exAluSrc && exExtOp));

  p_load_wb_r5: assert property (@(posedge clk) disable iff (!rstN)
    wbMemToReg |-> (wbRegWrite && $past(memRead)));

  p_no_wb_after_st_br_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memWrite || memBranch) |=> (!wbRegWrite && !wbMemToReg));

  p_pcsel_cond_r6: assert property (@(posedge clk) disable iff (!rstN)
    memPcSelTarget |-> (memBranch && memAluZero));

  p_unknown_bubble_r7: assert property (@(posedge clk) disable iff (!rstN)
    !knownOp |=> (!exExtOp && !exAluSrc && !exRegDst && exAluOp == 3'd0));
endmodule

bind pipeline_ctrl_unit mpc_checker u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .idOpcode       (idOpcode),
  .memAluZero     (memAluZero),
  .exExtOp        (exExtOp),
  .exAluSrc       (exAluSrc),
  .exAluOp        (exAluOp),
  .exRegDst       (exRegDst),
  .memRead        (memRead),
  .memWrite       (memWrite),
  .memBranch      (memBranch),
  .memPcSelTarget (memPcSelTarget),
  .wbMemToReg     (wbMemToReg),
  .wbRegWrite     (wbRegWrite)
);

// File: tb/sim_pipeline_ctrl_unit.sv
`timescale 1ns/1ps
module sim_pipeline_ctrl_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] idOpcode = 6'h23;
  logic [5:0] idFunct = 6'h20;
  logic       memAluZero = 1'b0;
  logic       exExtOp, exAluSrc, exRegDst;
  logic [2:0] exAluOp;
  logic       memRead, memWrite, memBranch, memPcSelTarget;
  logic       wbMemToReg, wbRegWrite;

  always #10 clk = ~clk;

  pipeline_ctrl_unit u0 (
    .clk(clk), .rstN(rstN), .idOpcode(idOpcode), .idFunct(idFunct),
    .memAluZero(memAluZero), .exExtOp(exExtOp), .exAluSrc(exAluSrc),
    .exAluOp(exAluOp), .exRegDst(exRegDst), .memRead(memRead),
    .memWrite(memWrite), .memBranch(memBranch), .memPcSelTarget(memPcSelTarget),
    .wbMemToReg(wbMemToReg), .wbRegWrite(wbRegWrite)
  );

  typedef struct packed {
    int unsigned due;
    logic [5:0]  v;
  } item_t;

  item_t       exQ[$];
  item_t       memQ[$];
  item_t       wbQ[$];
  bit          zeroTbl[int unsigned];
  int unsigned cyc = 0;
  bit          running = 1'b0;
  bit          done = 1'b0;
  int          nVec = 0;
  int          nBad = 0;

  // {extOp, aluSrc, regDst, aluOp[2:0], rd, wr, br, memToReg, regWrite}
  function automatic logic [10:0] model(input logic [5:0] op, input logic [5:0] fn);
    logic [2:0] a;
    case (fn)
      6'h22:   a = 3'd1;
      6'h24:   a = 3'd2;
      6'h25:   a = 3'd3;
      6'h2A:   a = 3'd4;
      default: a = 3'd0;
    endcase
    case (op)
      6'h00:   return {3'b001, a,    3'b000, 2'b01};
      6'h23:   return {3'b110, 3'd0, 3'b100, 2'b11};
      6'h2B:   return {3'b110, 3'd0, 3'b010, 2'b00};
      6'h04:   return {3'b100, 3'd1, 3'b001, 2'b00};
      6'h08:   return {3'b110, 3'd0, 3'b000, 2'b01};
      default: return 11'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [5:0] got, input logic [5:0] exp);
    nVec++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s cycle %0d: got %b expected %b", tag, cyc, got, exp);
    end
  endtask

  task automatic issue(input logic [5:0] op, input logic [5:0] fn, input bit z);
    logic [10:0] m;
    @(negedge clk);
    idOpcode = op;
    idFunct  = fn;
    m = model(op, fn);
    exQ.push_back('{due: cyc + 1, v: m[10:5]});
    memQ.push_back('{due: cyc + 2, v: {3'b000, m[4:2]}});
    wbQ.push_back('{due: cyc + 3, v: {4'b0000, m[1:0]}});
    zeroTbl[cyc + 2] = z;
  endtask

  // monitor: scoreboard pops the item due this cycle, zero when nothing is due (R1 fill)
  initial begin
    logic [5:0] exE, memE, wbE;
    forever begin
      @(posedge clk);
      #2;
      if (running) begin
        cyc++;
        memAluZero = zeroTbl.exists(cyc) ? zeroTbl[cyc] : 1'b0;
        #3;
        exE = '0; memE = '0; wbE = '0;
        if (exQ.size() > 0 && exQ[0].due == cyc) exE = exQ.pop_front().v;
        if (memQ.size() > 0 && memQ[0].due == cyc) memE = memQ.pop_front().v;
        if (wbQ.size() > 0 && wbQ[0].due == cyc) wbE = wbQ.pop_front().v;
        check("R2 exec strobes", {3'b000, exExtOp, exAluSrc, exRegDst}, {3'b000, exE[5:3]});
        check("R3 alu op", {3'b000, exAluOp}, {3'b000, exE[2:0]});
        check("R4 mem strobes", {3'b000, memRead, memWrite, memBranch}, memE);
        check("R5 wb strobes", {4'b0000, wbMemToReg, wbRegWrite}, wbE);
        check("R6 pc select", {5'b0, memPcSelTarget}, {5'b0, memE[0] & memAluZero});
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      nVec++;
      nBad++;
      $display("FAIL R8 watchdog expired at cycle %0d: got hang expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    // R1: load opcode present during reset must not leak to any output
    repeat (3) @(posedge clk);
    #5;
    check("R1 reset exec", {exExtOp, exAluSrc, exRegDst, exAluOp}, 6'd0);
    check("R1 reset mem/wb", {memRead, memWrite, memBranch, memPcSelTarget, wbMemToReg, wbRegWrite}, 6'd0);
    @(negedge clk);
    rstN = 1'b1;
    idOpcode = 6'h3F;
    running = 1'b1;
    // R8: back-to-back mixed stream, every stage holds a different instruction
    issue(6'h23, 6'h00, 1'b1);  // load, zero high but no branch (R6)
    issue(6'h00, 6'h20, 1'b0);  // rr add
    issue(6'h2B, 6'h00, 1'b0);  // store
    issue(6'h08, 6'h22, 1'b1);  // add-immediate, funct ignored (R3)
    issue(6'h04, 6'h00, 1'b1);  // branch taken (R6)
    issue(6'h00, 6'h22, 1'b0);  // rr sub
    issue(6'h00, 6'h24, 1'b0);  // rr and
    issue(6'h00, 6'h25, 1'b1);  // rr or
    issue(6'h00, 6'h2A, 1'b0);  // rr slt
    issue(6'h00, 6'h11, 1'b0);  // rr unknown funct -> add (R3)
    issue(6'h3F, 6'h20, 1'b1);  // R7 unknown opcode
    issue(6'h04, 6'h00, 1'b0);  // branch not taken (R6)
    issue(6'h23, 6'h00, 1'b0);  // load
    issue(6'h23, 6'h00, 1'b0);  // load back to back
    issue(6'h02, 6'h00, 1'b0);  // R7 another unknown opcode
    issue(6'h04, 6'h00, 1'b1);  // branch taken
    repeat (4) issue(6'h3F, 6'h00, 1'b0);
    repeat (3) @(posedge clk);
    #8;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule